// File: doc/BRIEF.md
# Link Rate Upgrade Sequencer

This block is a small hardware master that tries to move a serial link from the 2.5 GT/s rate up to 5 GT/s. It does this by driving the link controller's register port through a fixed series of single-beat reads and writes. A one-cycle start pulse launches the series, which has three stages.

The first stage applies two gates before any write is made. One gate checks that the link partner can run at the higher rate. The other checks that no rate change is already in flight. The second stage prepares the change. It programs the target rate with a read-modify-write, marks the change as deliberate, and clears any stale completion flags. It then starts the change by setting the in-flight bit. The third stage polls the status register once per millisecond tick until the finish flag shows up or a tick budget runs out.

When the series ends, the block holds its result lines until the next start pulse. The results are done, success, fail, timeout and busy error, plus a flag that tells whether the link now runs at 5 GT/s. The intended use is once during controller bring-up, before bus enumeration.

Top module: `link_rate_upgrader`

## Requirements
- R1: While reset is held and after it is released, all result outputs are 0 and no bus request is raised until a start pulse arrives.
- R2: The first access is a read of address 0x011078. If its bits [19:16] differ from 2, the run ends with done=1, all other results 0, and no bus write at all.
- R3: The second access reads address 0x011058. If bit 24 is already 1, the run ends with done=1 and busy_err=1, and makes no bus write.
- R4: The third access reads status address 0x011054 once. If bits [19:16] equal 2, the run ends with done=1, success=1 and speed_5g=1, and makes no bus write.
- R5: The target-rate word at parameter LNK_ADDR is read and then written back with bits [3:0] set to 2 and all other bits unchanged.
- R6: Address 0x011084 is read and then written back with bit 31 cleared and all other bits unchanged.
- R7: The status value from the setup read is written back to 0x011054 only if any of its bits 4, 6 or 7 is 1. Otherwise the setup makes no status write.
- R8: Address 0x011058 is read again and then written back with bit 24 set and all other bits unchanged. This write starts the change.
- R9: After that write, exactly one status read is made per tick. When a read shows bit 4 set, that same value is written back to the status address. The run then ends with fail equal to bit 6 of the read and success equal to its inverse.
- R10: If TIMEOUT_TICKS polls in a row show bit 4 clear, the run ends with done=1 and timeout=1, and makes no further write.
- R11: At most one of success, fail, timeout and busy_err is 1. speed_5g is 1 exactly when bits [19:16] of the last status read equal 2, and is 0 when the run ended before any status read.
- R12: Results hold until the next start pulse. A start pulse that arrives while a run is in progress is ignored.
- R13: A bus request holds its write flag, address and write data stable until it is acknowledged. Only one access is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle pulse that begins a run |
| tick_i | input | 1 | One-cycle millisecond tick |
| bus_req_o | output | 1 | Register access request (valid) |
| bus_we_o | output | 1 | 1 for write, 0 for read |
| bus_addr_o | output | ADDR_W | Register byte address |
| bus_wdata_o | output | DATA_W | Write data |
| bus_ack_i | input | 1 | Access accepted; read data valid in the same cycle |
| bus_rdata_i | input | DATA_W | Read data |
| done_o | output | 1 | Run finished |
| success_o | output | 1 | Link rate is at 5 GT/s by request or already |
| fail_o | output | 1 | Controller reported a failed change |
| timeout_o | output | 1 | No finish flag within the tick budget |
| busy_err_o | output | 1 | A change was already in flight |
| speed_5g_o | output | 1 | Last status read showed 5 GT/s |

## Verification
The result lines are registered. They change on the clock edge after the final acknowledgement, or after the read that ended the run. A bus request rises one edge after the sequencer asks for it, and each following access starts two edges after the previous acknowledgement. Because of this chain of registers, the bench never predicts an exact cycle count. It samples on falling edges, waits for done to rise, and only then compares the flags and the write log. It checks the ignored start pulse and the holding of results after the run has finished, by reading the capture count and the flags at the ports. It checks the timeout run by counting status reads, which must equal one setup read plus the tick budget.

// File: rtl/lru_pkg.sv
package lru_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CAP,
    ST_CTL,
    ST_STS,
    ST_LNK_RD,
    ST_LNK_WR,
    ST_RSN_RD,
    ST_RSN_WR,
    ST_CLR,
    ST_GO_RD,
    ST_GO_WR,
    ST_WAIT,
    ST_POLL,
    ST_ACK
  } seq_state_e;

  typedef struct packed {
    logic done;
    logic success;
    logic fail;
    logic timeout;
    logic busy_err;
    logic speed_5g;
  } seq_result_t;

  // Controller register offsets (decoded by the controller)
  localparam logic [31:0] OFS_CAP = 32'h0001_1078;
  localparam logic [31:0] OFS_CTL = 32'h0001_1058;
  localparam logic [31:0] OFS_STS = 32'h0001_1054;
  localparam logic [31:0] OFS_RSN = 32'h0001_1084;

  // Rate field in capability/status words
  localparam int          SPD_LSB = 16;
  localparam int          SPD_W   = 4;
  localparam logic [3:0]  SPD_5G  = 4'd2;

  // Target-rate field in the link control word
  localparam int          TGT_W   = 4;
  localparam logic [3:0]  TGT_5G  = 4'd2;

  localparam int          CTL_CHG_BIT  = 24;
  localparam int          STS_FIN_BIT  = 4;
  localparam int          STS_FAIL_BIT = 6;
  localparam int          STS_SUCC_BIT = 7;
  localparam int          RSN_BIT      = 31;

endpackage

// File: rtl/lru_bus_port.sv
module lru_bus_port #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              bus_req_o,
  output logic              bus_we_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic              bus_ack_i,
  input  logic [DATA_W-1:0] bus_rdata_i,
  output logic              rsp_o,
  output logic [DATA_W-1:0] rdata_o
);

  logic              req_q, req_n;
  logic              we_q, we_n;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic [DATA_W-1:0] wdata_q, wdata_n;
  logic              rsp_q, rsp_n;
  logic [DATA_W-1:0] rdata_q, rdata_n;
  logic              accept;

  assign accept = req_q && bus_ack_i;

  always_comb begin
    req_n   = req_q;
    we_n    = we_q;
    addr_n  = addr_q;
    wdata_n = wdata_q;
    rdata_n = rdata_q;
    rsp_n   = accept;
    if (go_i) begin
      req_n   = 1'b1;
      we_n    = we_i;
      addr_n  = addr_i;
      wdata_n = wdata_i;
    end else if (accept) begin
      req_n = 1'b0;
    end
    if (accept && !we_q) begin
      rdata_n = bus_rdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q   <= 1'b0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rsp_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      req_q   <= req_n;
      we_q    <= we_n;
      addr_q  <= addr_n;
      wdata_q <= wdata_n;
      rsp_q   <= rsp_n;
      rdata_q <= rdata_n;
    end
  end

  assign bus_req_o   = req_q;
  assign bus_we_o    = we_q;
  assign bus_addr_o  = addr_q;
  assign bus_wdata_o = wdata_q;
  assign rsp_o       = rsp_q;
  assign rdata_o     = rdata_q;

  // R13: an unacknowledged request keeps its command stable
  a_r13_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_o && !bus_ack_i) |=>
      (bus_req_o && $stable(bus_we_o) && $stable(bus_addr_o) && $stable(bus_wdata_o)));

  // R13: no new command while one is outstanding
  a_r13_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    go_i |-> !bus_req_o);

endmodule

// File: rtl/lru_tick_timer.sv
module lru_tick_timer #(
  parameter int LIMIT = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic inc_i,
  output logic expired_o
);

  localparam int CNT_W = $clog2(LIMIT + 1);
  localparam logic [CNT_W-1:0] LIMIT_C = CNT_W'(LIMIT);

  logic [CNT_W-1:0] cnt_q, cnt_n;

  always_comb begin
    cnt_n = cnt_q;
    if (clr_i) begin
      cnt_n = '0;
    end else if (inc_i && (cnt_q != LIMIT_C)) begin
      cnt_n = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_n;
    end
  end

  assign expired_o = (cnt_q == LIMIT_C);

  // R10: the poll count never runs past the budget
  a_r10_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIMIT_C);

endmodule

// File: rtl/lru_fsm.sv
module lru_fsm
  import lru_pkg::*;
#(
  parameter int              ADDR_W   = 24,
  parameter int              DATA_W   = 32,
  parameter logic [31:0]     LNK_ADDR = 32'h0000_70D0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              tick_i,
  output logic              go_o,
  output logic              we_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  input  logic              rsp_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              tmr_clr_o,
  output logic              tmr_inc_o,
  input  logic              tmr_expired_i,
  output seq_result_t       res_o
);

  localparam logic [ADDR_W-1:0] A_CAP = ADDR_W'(OFS_CAP);
  localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(OFS_CTL);
  localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(OFS_STS);
  localparam logic [ADDR_W-1:0] A_RSN = ADDR_W'(OFS_RSN);
  localparam logic [ADDR_W-1:0] A_LNK = ADDR_W'(LNK_ADDR);
  localparam logic [DATA_W-1:0] STALE_MASK =
    (DATA_W'(1) << STS_FIN_BIT) | (DATA_W'(1) << STS_FAIL_BIT) | (DATA_W'(1) << STS_SUCC_BIT);
  localparam logic [DATA_W-1:0] TGT_MASK = DATA_W'((1 << TGT_W) - 1);

  seq_state_e        state_q, state_n;
  seq_result_t       res_q, res_n;
  logic [DATA_W-1:0] sts_q, sts_n;
  logic              pend_q, pend_n;
  logic              capok_q, capok_n;
  logic              access;
  logic              rd_fast;

  assign rd_fast = (rdata_i[SPD_LSB +: SPD_W] == SPD_5G);
  assign access  = (state_q != ST_IDLE) && (state_q != ST_WAIT);
  assign go_o    = access && !pend_q;

  // Command decode per state
  always_comb begin
    we_o    = 1'b0;
    addr_o  = A_STS;
    wdata_o = '0;
    unique case (state_q)
      ST_CAP:    addr_o = A_CAP;
      ST_CTL:    addr_o = A_CTL;
      ST_STS:    addr_o = A_STS;
      ST_LNK_RD: addr_o = A_LNK;
      ST_LNK_WR: begin
        we_o    = 1'b1;
        addr_o  = A_LNK;
        wdata_o = (rdata_i & ~TGT_MASK) | DATA_W'(TGT_5G);
      end
      ST_RSN_RD: addr_o = A_RSN;
      ST_RSN_WR: begin
        we_o    = 1'b1;
        addr_o  = A_RSN;
        wdata_o = rdata_i & ~(DATA_W'(1) << RSN_BIT);
      end
      ST_CLR: begin
        we_o    = 1'b1;
        addr_o  = A_STS;
        wdata_o = sts_q;
      end
      ST_GO_RD:  addr_o = A_CTL;
      ST_GO_WR: begin
        we_o    = 1'b1;
        addr_o  = A_CTL;
        wdata_o = rdata_i | (DATA_W'(1) << CTL_CHG_BIT);
      end
      ST_POLL:   addr_o = A_STS;
      ST_ACK: begin
        we_o    = 1'b1;
        addr_o  = A_STS;
        wdata_o = rdata_i;
      end
      default: ;
    endcase
  end

  // Next-state logic
  always_comb begin
    state_n   = state_q;
    res_n     = res_q;
    sts_n     = sts_q;
    capok_n   = capok_q;
    pend_n    = pend_q;
    tmr_clr_o = 1'b0;
    tmr_inc_o = 1'b0;
    if (go_o)  pend_n = 1'b1;
    if (rsp_i) pend_n = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_n = ST_CAP;
        res_n   = '0;
        capok_n = 1'b0;
      end
      ST_CAP: if (rsp_i) begin
        if (rd_fast) begin
          state_n = ST_CTL;
          capok_n = 1'b1;
        end else begin
          state_n    = ST_IDLE;
          res_n.done = 1'b1;
        end
      end
      ST_CTL: if (rsp_i) begin
        if (rdata_i[CTL_CHG_BIT]) begin
          state_n        = ST_IDLE;
          res_n.done     = 1'b1;
          res_n.busy_err = 1'b1;
        end else begin
          state_n = ST_STS;
        end
      end
      ST_STS: if (rsp_i) begin
        sts_n = rdata_i;
        if (rd_fast) begin
          state_n        = ST_IDLE;
          res_n.done     = 1'b1;
          res_n.success  = 1'b1;
          res_n.speed_5g = 1'b1;
        end else begin
          state_n = ST_LNK_RD;
        end
      end
      ST_LNK_RD: if (rsp_i) state_n = ST_LNK_WR;
      ST_LNK_WR: if (rsp_i) state_n = ST_RSN_RD;
      ST_RSN_RD: if (rsp_i) state_n = ST_RSN_WR;
      ST_RSN_WR: if (rsp_i) state_n = ((sts_q & STALE_MASK) != '0) ? ST_CLR : ST_GO_RD;
      ST_CLR:    if (rsp_i) state_n = ST_GO_RD;
      ST_GO_RD:  if (rsp_i) state_n = ST_GO_WR;
      ST_GO_WR: if (rsp_i) begin
        state_n   = ST_WAIT;
        tmr_clr_o = 1'b1;
      end
      ST_WAIT: if (tick_i) begin
        state_n   = ST_POLL;
        tmr_inc_o = 1'b1;
      end
      ST_POLL: if (rsp_i) begin
        if (rdata_i[STS_FIN_BIT]) begin
          state_n = ST_ACK;
        end else if (tmr_expired_i) begin
          state_n        = ST_IDLE;
          res_n.done     = 1'b1;
          res_n.timeout  = 1'b1;
          res_n.speed_5g = rd_fast;
        end else begin
          state_n = ST_WAIT;
        end
      end
      ST_ACK: if (rsp_i) begin
        state_n        = ST_IDLE;
        res_n.done     = 1'b1;
        res_n.fail     = rdata_i[STS_FAIL_BIT];
        res_n.success  = !rdata_i[STS_FAIL_BIT];
        res_n.speed_5g = rd_fast;
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      res_q   <= '0;
      sts_q   <= '0;
      pend_q  <= 1'b0;
      capok_q <= 1'b0;
    end else begin
      state_q <= state_n;
      res_q   <= res_n;
      sts_q   <= sts_n;
      pend_q  <= pend_n;
      capok_q <= capok_n;
    end
  end

  assign res_o = res_q;

  // R2: no write is issued before the capability gate has passed
  a_r2_write_after_cap: assert property (@(posedge clk) disable iff (!rst_n)
    (go_o && we_o) |-> capok_q);

  // R8: every control write carries the change-start bit
  a_r8_start_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (go_o && we_o && addr_o == A_CTL) |-> wdata_o[CTL_CHG_BIT]);

  // R6: every reason write has the reason bit cleared
  a_r6_reason_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (go_o && we_o && addr_o == A_RSN) |-> !wdata_o[RSN_BIT]);

  // R11: outcome flags are mutually exclusive
  a_r11_flags_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({res_q.success, res_q.fail, res_q.timeout, res_q.busy_err}));

  // R12: results hold while idle without a start pulse
  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !start_i) |=> $stable(res_q));

  // R12: a start pulse during a run leaves the results cleared
  a_r12_ignore_start: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE && start_i && !res_q.done) |=> (state_n == ST_IDLE || !res_q.done));

endmodule

// File: rtl/link_rate_upgrader.sv
module link_rate_upgrader
  import lru_pkg::*;
#(
  parameter int          ADDR_W        = 24,
  parameter int          DATA_W        = 32,
  parameter int          TIMEOUT_TICKS = 1000,
  parameter logic [31:0] LNK_ADDR      = 32'h0000_70D0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              tick_i,
  output logic              bus_req_o,
  output logic              bus_we_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic              bus_ack_i,
  input  logic [DATA_W-1:0] bus_rdata_i,
  output logic              done_o,
  output logic              success_o,
  output logic              fail_o,
  output logic              timeout_o,
  output logic              busy_err_o,
  output logic              speed_5g_o
);

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              go;
  logic              we;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] wdata;
  logic              rsp;
  logic [DATA_W-1:0] rdata;
  logic              tmr_clr;
  logic              tmr_inc;
  logic              tmr_expired;
  seq_result_t       res;

  // Reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  lru_fsm #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .LNK_ADDR (LNK_ADDR)
  ) u_fsm (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .start_i       (start_i),
    .tick_i        (tick_i),
    .go_o          (go),
    .we_o          (we),
    .addr_o        (addr),
    .wdata_o       (wdata),
    .rsp_i         (rsp),
    .rdata_i       (rdata),
    .tmr_clr_o     (tmr_clr),
    .tmr_inc_o     (tmr_inc),
    .tmr_expired_i (tmr_expired),
    .res_o         (res)
  );

  lru_bus_port #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_port (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .go_i        (go),
    .we_i        (we),
    .addr_i      (addr),
    .wdata_i     (wdata),
    .bus_req_o   (bus_req_o),
    .bus_we_o    (bus_we_o),
    .bus_addr_o  (bus_addr_o),
    .bus_wdata_o (bus_wdata_o),
    .bus_ack_i   (bus_ack_i),
    .bus_rdata_i (bus_rdata_i),
    .rsp_o       (rsp),
    .rdata_o     (rdata)
  );

  lru_tick_timer #(
    .LIMIT (TIMEOUT_TICKS)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .clr_i     (tmr_clr),
    .inc_i     (tmr_inc),
    .expired_o (tmr_expired)
  );

  assign done_o     = res.done;
  assign success_o  = res.success;
  assign fail_o     = res.fail;
  assign timeout_o  = res.timeout;
  assign busy_err_o = res.busy_err;
  assign speed_5g_o = res.speed_5g;

endmodule

// File: tb/link_rate_upgrader_tb.sv
`timescale 1ns/1ps
module link_rate_upgrader_tb;

  localparam int          AW       = 24;
  localparam int          DW       = 32;
  localparam int          TO_TICKS = 8;
  localparam int          TICK_DIV = 20;
  localparam int          FIN_DLY  = 50;
  localparam logic [31:0] LNK_A    = 32'h0000_70D0;
  localparam logic [AW-1:0] A_CAP = 24'h01_1078;
  localparam logic [AW-1:0] A_CTL = 24'h01_1058;
  localparam logic [AW-1:0] A_STS = 24'h01_1054;
  localparam logic [AW-1:0] A_RSN = 24'h01_1084;
  localparam logic [AW-1:0] A_LNK = LNK_A[AW-1:0];

  typedef struct packed {
    logic [3:0]  cap;
    logic [31:0] ctl;
    logic [31:0] sts;
    logic        fl;
    logic        nv;
    logic [4:0]  exp;   // {success, fail, timeout, busy_err, speed_5g}
    logic [3:0]  wr;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{4'd1, 32'h0,         32'h0001_0000, 1'b0, 1'b0, 5'b00000, 4'd0},  // R2
    '{4'd2, 32'h0100_0000, 32'h0001_0000, 1'b0, 1'b0, 5'b00010, 4'd0},  // R3
    '{4'd2, 32'h0,         32'h0002_0000, 1'b0, 1'b0, 5'b10001, 4'd0},  // R4
    '{4'd2, 32'h0,         32'h0001_0000, 1'b0, 1'b0, 5'b10001, 4'd4},  // R9
    '{4'd2, 32'h0,         32'h0001_00D0, 1'b0, 1'b0, 5'b10001, 4'd5},  // R7
    '{4'd2, 32'h0,         32'h0001_0000, 1'b1, 1'b0, 5'b01000, 4'd4},  // R9 fail
    '{4'd2, 32'h0,         32'h0001_0000, 1'b0, 1'b1, 5'b00100, 4'd3},  // R10
    '{4'd3, 32'h0,         32'h0001_0000, 1'b0, 1'b0, 5'b00000, 4'd0}   // R2
  };

  logic          clk, rst_n, start, tick;
  logic          req, we, ack;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata, rdata;
  logic          done, succ, fl, tmo, busy, spd;

  link_rate_upgrader #(
    .ADDR_W (AW), .DATA_W (DW), .TIMEOUT_TICKS (TO_TICKS), .LNK_ADDR (LNK_A)
  ) u_dut (
    .clk (clk), .rst_n (rst_n), .start_i (start), .tick_i (tick),
    .bus_req_o (req), .bus_we_o (we), .bus_addr_o (addr), .bus_wdata_o (wdata),
    .bus_ack_i (ack), .bus_rdata_i (rdata),
    .done_o (done), .success_o (succ), .fail_o (fl), .timeout_o (tmo),
    .busy_err_o (busy), .speed_5g_o (spd)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Register file model configuration (driven by the stimulus process)
  logic        load;
  logic [31:0] c_cap, c_ctl, c_sts, c_lnk, c_rsn;
  logic        c_fail, c_never;

  // Model state and logs (driven by the model process)
  logic [31:0] m_cap, m_ctl, m_sts, m_lnk, m_rsn, s_tmp;
  int          fin_cnt;
  logic        fin_arm;
  int          n_wr, n_sts_rd, n_cap_rd, n_sts_w, prot_err;
  logic [31:0] last_lnk_w, last_rsn_w, last_ctl_w, first_sts_w, last_sts_w;
  logic        prev_pend;
  logic [AW-1:0] prev_addr;

  always @(posedge clk) begin
    if (load) begin
      m_cap <= c_cap; m_ctl <= c_ctl; m_sts <= c_sts; m_lnk <= c_lnk; m_rsn <= c_rsn;
      fin_cnt <= 0; fin_arm <= 1'b0; ack <= 1'b0; rdata <= '0;
      n_wr <= 0; n_sts_rd <= 0; n_cap_rd <= 0; n_sts_w <= 0;
      last_lnk_w <= '0; last_rsn_w <= '0; last_ctl_w <= '0;
      first_sts_w <= '0; last_sts_w <= '0;
      prev_pend <= 1'b0; prev_addr <= '0;
    end else begin
      s_tmp = m_sts;
      ack <= 1'b0;
      if (prev_pend && req && addr != prev_addr) prot_err <= prot_err + 1;
      prev_pend <= req && !ack;
      prev_addr <= addr;
      if (fin_arm) begin
        if (fin_cnt == 0) begin
          s_tmp = (s_tmp & ~32'h000F_00D0) | 32'h10 |
                  (c_fail ? 32'h0001_0040 : 32'h0002_0080);
          m_ctl <= m_ctl & ~32'h0100_0000;
          fin_arm <= 1'b0;
        end else begin
          fin_cnt <= fin_cnt - 1;
        end
      end
      if (req && !ack) begin
        ack <= 1'b1;
        if (we) begin
          n_wr <= n_wr + 1;
          if (addr == A_LNK) begin m_lnk <= wdata; last_lnk_w <= wdata; end
          if (addr == A_RSN) begin m_rsn <= wdata; last_rsn_w <= wdata; end
          if (addr == A_CTL) begin
            m_ctl <= wdata; last_ctl_w <= wdata;
            if (wdata[24] && !c_never) begin fin_arm <= 1'b1; fin_cnt <= FIN_DLY; end
          end
          if (addr == A_STS) begin
            s_tmp = s_tmp & ~(wdata & 32'h0000_00D0);
            if (n_sts_w == 0) first_sts_w <= wdata;
            last_sts_w <= wdata;
            n_sts_w <= n_sts_w + 1;
          end
        end else begin
          rdata <= (addr == A_CAP) ? m_cap : (addr == A_CTL) ? m_ctl :
                   (addr == A_STS) ? s_tmp : (addr == A_LNK) ? m_lnk :
                   (addr == A_RSN) ? m_rsn : 32'hDEAD_BEEF;
          if (addr == A_STS) n_sts_rd <= n_sts_rd + 1;
          if (addr == A_CAP) n_cap_rd <= n_cap_rd + 1;
        end
      end
      m_sts <= s_tmp;
    end
  end

  int checks, errors;

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic setup(input logic [3:0] cap, input logic [31:0] ctl, input logic [31:0] sts,
                       input logic f, input logic nv);
    c_cap = {12'h0, cap, 16'h0}; c_ctl = ctl; c_sts = sts;
    c_lnk = 32'hABCD_0011; c_rsn = 32'h8000_1234; c_fail = f; c_never = nv;
    @(negedge clk); load = 1'b1;
    @(negedge clk); load = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_done();
    int n;
    n = 0;
    while (!done && n < 5000) begin @(negedge clk); n++; end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: done never rose actual=0 expected=1");
    end
  endtask

  // Millisecond tick stand-in
  initial begin
    tick = 1'b0;
    forever begin
      repeat (TICK_DIV - 1) @(negedge clk);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
    end
  end

  initial begin
    checks = 0; errors = 0; prot_err = 0;
    rst_n = 1'b0; start = 1'b0; load = 1'b0;
    setup(4'd2, 32'h0, 32'h0001_0000, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    // R1: reset state
    chk({done, succ, fl, tmo, busy, spd, req} == 7'b0, "R1 reset outputs",
        {25'h0, done, succ, fl, tmo, busy, spd, req}, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    repeat (10) @(negedge clk);
    chk({done, req} == 2'b0, "R1 idle after reset", {30'h0, done, req}, 32'h0);

    // Vector walk
    for (int i = 0; i < NV; i++) begin
      setup(VEC[i].cap, VEC[i].ctl, VEC[i].sts, VEC[i].fl, VEC[i].nv);
      pulse_start();
      wait_done();
      @(negedge clk);
      chk({succ, fl, tmo, busy, spd} == VEC[i].exp, $sformatf("R11 vector %0d flags", i),
          {27'h0, succ, fl, tmo, busy, spd}, {27'h0, VEC[i].exp});
      chk(n_wr == int'(VEC[i].wr), $sformatf("R2 R3 R4 vector %0d write count", i),
          n_wr, {28'h0, VEC[i].wr});
    end

    // R5 R6 R8 R9: field-preserving writes and finish write-back
    setup(4'd2, 32'h0800_0001, 32'h0001_0000, 1'b0, 1'b0);
    pulse_start();
    wait_done();
    @(negedge clk);
    chk(last_lnk_w == 32'hABCD_0012, "R5 target rate write", last_lnk_w, 32'hABCD_0012);
    chk(last_rsn_w == 32'h0000_1234, "R6 reason write", last_rsn_w, 32'h0000_1234);
    chk(last_ctl_w == 32'h0900_0001, "R8 start write", last_ctl_w, 32'h0900_0001);
    chk(n_sts_w == 1, "R7 no stale clear when flags clear", n_sts_w, 32'd1);
    chk(last_sts_w == 32'h0002_0090, "R9 finish write-back", last_sts_w, 32'h0002_0090);
    chk(succ && spd, "R11 speed after success", {30'h0, succ, spd}, 32'h3);

    // R7: stale flags cleared with the setup value
    setup(4'd2, 32'h0, 32'h0001_00D0, 1'b0, 1'b0);
    pulse_start();
    wait_done();
    @(negedge clk);
    chk(first_sts_w == 32'h0001_00D0, "R7 stale clear value", first_sts_w, 32'h0001_00D0);

    // R9 R10: one poll per tick, budget then timeout
    setup(4'd2, 32'h0, 32'h0001_0000, 1'b0, 1'b1);
    pulse_start();
    wait_done();
    @(negedge clk);
    chk(n_sts_rd == 1 + TO_TICKS, "R10 status reads at timeout", n_sts_rd, 1 + TO_TICKS);
    chk(tmo && !spd, "R10 timeout flag", {30'h0, tmo, spd}, 32'h2);

    // R12: start during a run ignored, results hold afterwards
    setup(4'd2, 32'h0, 32'h0001_0000, 1'b0, 1'b0);
    pulse_start();
    repeat (30) @(negedge clk);
    pulse_start();
    wait_done();
    repeat (40) @(negedge clk);
    chk(n_cap_rd == 1, "R12 second start ignored", n_cap_rd, 32'd1);
    chk(n_wr == 4, "R12 single run writes", n_wr, 32'd4);
    chk(done && succ && spd, "R12 results held", {29'h0, done, succ, spd}, 32'h7);

    // R13: command stability seen at the bus
    chk(prot_err == 0, "R13 request stable until ack", prot_err, 32'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: run hung actual=1 expected=0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule